// File: doc/BRIEF.md
# Register-Typed Packed SIMD Add/Subtract Unit

This unit holds a 32-entry, 32-bit integer register file in which every register is also a packed vector. One issued instruction names two source registers, one destination and an add or subtract select. The operands are read combinationally and split into lanes. The lane width does not come from the opcode: a per-register element-type table supplies it. Each lane is computed on its own, with no carry or borrow crossing into the next lane. The result is written back to the destination at the next clock edge.

By default the type table follows the upper half/lower half split of the register number:

- the lower half of the file holds 8-bit lanes;
- the upper half holds 16-bit lanes;
- the last two registers hold one full-width element.

A configuration port rewrites any entry of the table. A separate write port lets loaded data land in the file, and a peek port reads any register as a scalar.

The unit also decodes vector memory accesses, but only to raise a trap for the non-contiguous forms, which software then emulates.

Top module: `psimd_unit`

## Requirements
- R1: After reset every register reads zero. The peek port returns register `peek_idx_i` combinationally. A load write (`ld_we_i`) stores `ld_data_i` at the next rising clock edge.
- R2: Register 0 always reads zero, on the source operands and on the peek port. Any write to register 0 is discarded.
- R3: After reset the type code of each register is as follows. Registers 0 to 15 hold code 0 (four 8-bit lanes). Registers 16 to 29 hold code 1 (two 16-bit lanes). Registers 30 and 31 hold code 2 (one 32-bit element).
- R4: With `op_i`=0 each lane holds rs1+rs2, and with `op_i`=1 it holds rs1-rs2. Both wrap modulo the lane width, and no carry or borrow crosses a lane boundary.
- R5: The lane width is taken from the destination register's type. `mismatch_o` is 1 exactly when `issue_i` is high and the type of either source differs from the type of the destination.
- R6: A configuration write sets the type of `cfg_idx_i` to `cfg_type_i` at the next edge. The codes are 0=8-bit, 1=16-bit, 2=32-bit, and 3 (reserved) computes as 32-bit. An instruction issued in the same cycle as the configuration write still uses the old type.
- R7: A read of a register in the same cycle as a write to it returns the old value.
- R8: With `issue_i` high, `result_o` is valid combinationally and is written to `rd_i` at the next edge. If a load write targets the same register in the same cycle, the instruction result wins.
- R9: `trap_o` equals `vmem_i` AND (`vmem_mode_i` != 0), where mode 0 is unit-stride, 1 is strided, 2 is indexed and 3 is reserved. A trapped access leaves both the registers and the type table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Instruction valid |
| op_i | input | 1 | 0 add, 1 subtract |
| rs1_i | input | 5 | First source register |
| rs2_i | input | 5 | Second source register |
| rd_i | input | 5 | Destination register |
| result_o | output | 32 | Lane-wise result |
| mismatch_o | output | 1 | Source and destination types differ |
| ld_we_i | input | 1 | Load data write enable |
| ld_idx_i | input | 5 | Load data target register |
| ld_data_i | input | 32 | Load data |
| cfg_we_i | input | 1 | Type table write enable |
| cfg_idx_i | input | 5 | Register whose type is set |
| cfg_type_i | input | 2 | New type code |
| vmem_i | input | 1 | Vector memory access decoded |
| vmem_mode_i | input | 2 | Access form |
| trap_o | output | 1 | Access must be emulated |
| peek_idx_i | input | 5 | Scalar read index |
| peek_data_o | output | 32 | Scalar read data |

## Verification
The bench builds the unit with its default parameters: 32 registers of 32 bits, with two full-width registers at the top. With these values the 8/16 boundary between registers 15 and 16 and the 16/32 boundary between registers 29 and 30 are both reachable by the bench. A fixed-seed random mix of loads, type rewrites, issues and memory decodes then crosses every type pairing, including the reserved code. Directed cases add the following:

- all-ones lanes that would carry into the neighbouring lane;
- writes to register 0;
- a same-cycle read of a register being written;
- a type rewrite with an issue in the same cycle;
- a load colliding with an instruction write to the same register.

// File: rtl/psimd_pkg.sv
package psimd_pkg;
  typedef enum logic [1:0] {
    ET_8   = 2'd0,
    ET_16  = 2'd1,
    ET_32  = 2'd2,
    ET_RSV = 2'd3
  } elem_t;

  typedef enum logic [1:0] {
    VM_UNIT    = 2'd0,
    VM_STRIDED = 2'd1,
    VM_INDEXED = 2'd2,
    VM_RSV     = 2'd3
  } vmem_mode_t;
endpackage

// File: rtl/psimd_regfile.sv
module psimd_regfile #(
  parameter int NUM_REGS = 32,
  parameter int XLEN     = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] ra_idx_i,
  input  logic [IDX_W-1:0] rb_idx_i,
  input  logic [IDX_W-1:0] rc_idx_i,
  output logic [XLEN-1:0]  ra_o,
  output logic [XLEN-1:0]  rb_o,
  output logic [XLEN-1:0]  rc_o,
  input  logic             alu_we_i,
  input  logic [IDX_W-1:0] alu_idx_i,
  input  logic [XLEN-1:0]  alu_data_i,
  input  logic             ld_we_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [XLEN-1:0]  ld_data_i
);
  logic [XLEN-1:0] mem_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 1; i < NUM_REGS; i++) begin
        if (alu_we_i && alu_idx_i == IDX_W'(i))     mem_q[i] <= alu_data_i;
        else if (ld_we_i && ld_idx_i == IDX_W'(i))  mem_q[i] <= ld_data_i;
      end
    end
  end

  assign ra_o = (ra_idx_i == '0) ? '0 : mem_q[ra_idx_i];
  assign rb_o = (rb_idx_i == '0) ? '0 : mem_q[rb_idx_i];
  assign rc_o = (rc_idx_i == '0) ? '0 : mem_q[rc_idx_i];

  // R2
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_we_i || ld_we_i) |=> mem_q[0] == '0);

  // R8
  alu_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_we_i && alu_idx_i != '0) |=> mem_q[$past(alu_idx_i)] == $past(alu_data_i));

  // R1
  ld_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_we_i && ld_idx_i != '0 && !(alu_we_i && alu_idx_i == ld_idx_i))
      |=> mem_q[$past(ld_idx_i)] == $past(ld_data_i));
endmodule

// File: rtl/psimd_type_table.sv
module psimd_type_table
  import psimd_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int WIDE_REGS = 2,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  elem_t            cfg_type_i,
  input  logic [IDX_W-1:0] ra_idx_i,
  input  logic [IDX_W-1:0] rb_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output elem_t            ra_type_o,
  output elem_t            rb_type_o,
  output elem_t            rd_type_o
);
  elem_t tbl_q [NUM_REGS];

  function automatic elem_t default_type(int idx);
    if (idx >= NUM_REGS - WIDE_REGS) return ET_32;
    if (idx >= NUM_REGS / 2)         return ET_16;
    return ET_8;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) tbl_q[i] <= default_type(i);
    end else if (cfg_we_i) begin
      tbl_q[cfg_idx_i] <= cfg_type_i;
    end
  end

  assign ra_type_o = tbl_q[ra_idx_i];
  assign rb_type_o = tbl_q[rb_idx_i];
  assign rd_type_o = tbl_q[rd_idx_i];

  // R6
  cfg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> tbl_q[$past(cfg_idx_i)] == $past(cfg_type_i));

  // R6
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && $past(rst_ni)) |=> tbl_q[$past(rd_idx_i)] == $past(rd_type_o));
endmodule

// File: rtl/psimd_lane_alu.sv
module psimd_lane_alu #(
  parameter int XLEN   = 32,
  parameter int LANE_W = 8,
  localparam int LANES = XLEN / LANE_W
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] y_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] a_l, b_l;
    assign a_l = a_i[l*LANE_W +: LANE_W];
    assign b_l = sub_i ? ~b_i[l*LANE_W +: LANE_W] : b_i[l*LANE_W +: LANE_W];
    // carry-in per lane only; carry-out dropped
    assign y_o[l*LANE_W +: LANE_W] = a_l + b_l + {{(LANE_W-1){1'b0}}, sub_i};
  end
endmodule

// File: rtl/psimd_unit.sv
module psimd_unit
  import psimd_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int XLEN      = 32,
  parameter int WIDE_REGS = 2,
  parameter int NARROW_W  = 8,
  parameter int MID_W     = 16,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic             op_i,
  input  logic [IDX_W-1:0] rs1_i,
  input  logic [IDX_W-1:0] rs2_i,
  input  logic [IDX_W-1:0] rd_i,
  output logic [XLEN-1:0]  result_o,
  output logic             mismatch_o,
  input  logic             ld_we_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [XLEN-1:0]  ld_data_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [1:0]       cfg_type_i,
  input  logic             vmem_i,
  input  logic [1:0]       vmem_mode_i,
  output logic             trap_o,
  input  logic [IDX_W-1:0] peek_idx_i,
  output logic [XLEN-1:0]  peek_data_o
);
  logic [XLEN-1:0] opa, opb, y_n, y_m, y_w;
  elem_t           ta, tb, td;

  psimd_regfile #(.NUM_REGS(NUM_REGS), .XLEN(XLEN)) u_rf (
    .clk_i, .rst_ni,
    .ra_idx_i(rs1_i), .rb_idx_i(rs2_i), .rc_idx_i(peek_idx_i),
    .ra_o(opa), .rb_o(opb), .rc_o(peek_data_o),
    .alu_we_i(issue_i), .alu_idx_i(rd_i), .alu_data_i(result_o),
    .ld_we_i, .ld_idx_i, .ld_data_i
  );

  psimd_type_table #(.NUM_REGS(NUM_REGS), .WIDE_REGS(WIDE_REGS)) u_tt (
    .clk_i, .rst_ni,
    .cfg_we_i, .cfg_idx_i, .cfg_type_i(elem_t'(cfg_type_i)),
    .ra_idx_i(rs1_i), .rb_idx_i(rs2_i), .rd_idx_i(rd_i),
    .ra_type_o(ta), .rb_type_o(tb), .rd_type_o(td)
  );

  psimd_lane_alu #(.XLEN(XLEN), .LANE_W(NARROW_W)) u_alu_n (.a_i(opa), .b_i(opb), .sub_i(op_i), .y_o(y_n));
  psimd_lane_alu #(.XLEN(XLEN), .LANE_W(MID_W))    u_alu_m (.a_i(opa), .b_i(opb), .sub_i(op_i), .y_o(y_m));
  psimd_lane_alu #(.XLEN(XLEN), .LANE_W(XLEN))     u_alu_w (.a_i(opa), .b_i(opb), .sub_i(op_i), .y_o(y_w));

  // destination type picks the lane split; reserved code runs full width
  always_comb begin
    unique case (td)
      ET_8:    result_o = y_n;
      ET_16:   result_o = y_m;
      default: result_o = y_w;
    endcase
  end

  assign mismatch_o = issue_i && (ta != td || tb != td);
  assign trap_o     = vmem_i && (vmem_mode_t'(vmem_mode_i) != VM_UNIT);

  // R5
  mismatch_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |-> issue_i);

  // R9
  trap_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (vmem_i && vmem_mode_i != 2'd0));

  // R2
  zero_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (peek_idx_i == '0) |-> peek_data_o == '0);
endmodule

// File: tb/psimd_unit_bench.sv
`timescale 1ns/1ps
module psimd_unit_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        issue, op, ld_we, cfg_we, vmem;
  logic [4:0]  rs1, rs2, rd, ld_idx, cfg_idx, peek_idx;
  logic [31:0] ld_data, result, peek_data;
  logic [1:0]  cfg_type, vmode;
  logic        mismatch, trap;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_reg [32];
  logic [1:0]  m_typ [32];

  always #2 clk = ~clk;

  psimd_unit u_psimd_unit (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .op_i(op),
    .rs1_i(rs1), .rs2_i(rs2), .rd_i(rd), .result_o(result), .mismatch_o(mismatch),
    .ld_we_i(ld_we), .ld_idx_i(ld_idx), .ld_data_i(ld_data),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_type_i(cfg_type),
    .vmem_i(vmem), .vmem_mode_i(vmode), .trap_o(trap),
    .peek_idx_i(peek_idx), .peek_data_o(peek_data)
  );

  function automatic logic [31:0] lane_op(logic [31:0] a, logic [31:0] b, bit sub, logic [1:0] t);
    int w = (t == 2'd0) ? 8 : (t == 2'd1) ? 16 : 32;
    logic [31:0] mask = (w == 32) ? 32'hffff_ffff : ((32'd1 << w) - 1);
    logic [31:0] r = '0;
    for (int l = 0; l < 32 / w; l++) begin
      logic [31:0] av = (a >> (l * w)) & mask;
      logic [31:0] bv = (b >> (l * w)) & mask;
      logic [31:0] s  = sub ? av - bv : av + bv;
      r |= (s & mask) << (l * w);
    end
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic idle();
    issue = 0; op = 0; rs1 = 0; rs2 = 0; rd = 0;
    ld_we = 0; ld_idx = 0; ld_data = 0;
    cfg_we = 0; cfg_idx = 0; cfg_type = 0;
    vmem = 0; vmode = 0; peek_idx = 0;
  endtask

  // inputs already driven; check comb outputs, clock once, update model
  task automatic step(string tag);
    logic [31:0] a, b, er;
    bit em;
    #1;
    a  = (rs1 == 0) ? 32'd0 : m_reg[rs1];
    b  = (rs2 == 0) ? 32'd0 : m_reg[rs2];
    er = lane_op(a, b, op, m_typ[rd]);
    em = issue && (m_typ[rs1] != m_typ[rd] || m_typ[rs2] != m_typ[rd]);
    if (issue) chk(result === er, tag, result, er);
    chk(mismatch === em, tag, {31'd0, mismatch}, {31'd0, em});
    chk(trap === (vmem && vmode != 0), tag, {31'd0, trap}, {31'd0, vmem && vmode != 0});
    chk(peek_data === ((peek_idx == 0) ? 32'd0 : m_reg[peek_idx]), tag, peek_data,
        (peek_idx == 0) ? 32'd0 : m_reg[peek_idx]);
    @(posedge clk);
    if (ld_we && ld_idx != 0) m_reg[ld_idx] = ld_data;
    if (issue && rd != 0) m_reg[rd] = er;
    if (cfg_we) m_typ[cfg_idx] = cfg_type;
    @(negedge clk);
    idle();
  endtask

  task automatic load(logic [4:0] i, logic [31:0] d, string tag);
    ld_we = 1; ld_idx = i; ld_data = d; step(tag);
  endtask

  task automatic exec(bit o, logic [4:0] a, logic [4:0] b, logic [4:0] d, string tag);
    issue = 1; op = o; rs1 = a; rs2 = b; rd = d; step(tag);
  endtask

  task automatic peek(logic [4:0] i, string tag);
    peek_idx = i; step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    for (int i = 0; i < 32; i++) begin
      m_reg[i] = '0;
      m_typ[i] = (i >= 30) ? 2'd2 : (i >= 16) ? 2'd1 : 2'd0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state of all registers
    for (int i = 0; i < 32; i++) peek(5'(i), "R1");

    // R3: default types at the 15/16 and 29/30 boundaries
    load(5'd15, 32'h80FF_7F01, "R1");
    load(5'd16, 32'h80FF_7F01, "R1");
    load(5'd29, 32'h80FF_7F01, "R1");
    load(5'd30, 32'h80FF_7F01, "R1");
    load(5'd31, 32'h0101_0101, "R1");
    exec(0, 5'd15, 5'd15, 5'd14, "R3");
    exec(0, 5'd16, 5'd16, 5'd17, "R3");
    exec(0, 5'd29, 5'd29, 5'd28, "R3");
    exec(0, 5'd30, 5'd30, 5'd30, "R3");
    peek(5'd30, "R3");

    // R4: all-ones lanes plus one, zero minus one
    load(5'd1, 32'hFFFF_FFFF, "R4");
    load(5'd2, 32'h0101_0101, "R4");
    exec(0, 5'd1, 5'd2, 5'd3, "R4");
    exec(1, 5'd0, 5'd2, 5'd4, "R4");
    load(5'd18, 32'h0001_0001, "R4");
    exec(1, 5'd0, 5'd18, 5'd19, "R4");
    exec(0, 5'd1, 5'd31, 5'd20, "R5");
    peek(5'd20, "R4");

    // R2: writes to register 0 discarded
    load(5'd0, 32'hDEAD_BEEF, "R2");
    exec(0, 5'd1, 5'd2, 5'd0, "R2");
    peek(5'd0, "R2");

    // R7: same-cycle read and write return old value
    issue = 1; rs1 = 5'd5; rs2 = 5'd2; rd = 5'd6;
    ld_we = 1; ld_idx = 5'd5; ld_data = 32'h1234_5678; peek_idx = 5'd5;
    step("R7");
    peek(5'd5, "R7");

    // R8: instruction write wins over load to same register
    issue = 1; rs1 = 5'd2; rs2 = 5'd2; rd = 5'd7;
    ld_we = 1; ld_idx = 5'd7; ld_data = 32'hCAFE_F00D;
    step("R8");
    peek(5'd7, "R8");

    // R6: same-cycle config uses old type, next cycle new type; reserved runs full width
    issue = 1; rs1 = 5'd1; rs2 = 5'd2; rd = 5'd8;
    cfg_we = 1; cfg_idx = 5'd8; cfg_type = 2'd1;
    step("R6");
    exec(0, 5'd1, 5'd2, 5'd8, "R6");
    cfg_we = 1; cfg_idx = 5'd9; cfg_type = 2'd3; step("R6");
    exec(0, 5'd1, 5'd2, 5'd9, "R6");

    // R9: every access form, no side effects
    for (int m = 0; m < 4; m++) begin
      vmem = 1; vmode = 2'(m); peek_idx = 5'd9; step("R9");
    end
    vmem = 0; vmode = 2'd2; step("R9");

    // R5/R4 random mix
    for (int n = 0; n < 3000; n++) begin
      issue   = $urandom_range(0, 3) != 0;
      op      = 1'($urandom);
      rs1     = 5'($urandom); rs2 = 5'($urandom); rd = 5'($urandom);
      ld_we   = $urandom_range(0, 2) == 0;
      ld_idx  = 5'($urandom); ld_data = $urandom;
      cfg_we  = $urandom_range(0, 9) == 0;
      cfg_idx = 5'($urandom); cfg_type = 2'($urandom);
      vmem    = 1'($urandom); vmode = 2'($urandom);
      peek_idx = 5'($urandom);
      step("R5");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule